// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshaked Binary Pointer Transfer

This block moves data words from a write clock domain to an unrelated read clock domain through a small register array. Each side keeps its own pointer in plain binary, one bit wider than the address. The sender takes a snapshot of its pointer into a hold register and raises a ready line. The receiver synchronizes that line, copies the snapshot and returns an acknowledge. The sender does not touch the snapshot until that acknowledge has come back through its own synchronizer. Only then does it drop ready, wait for the acknowledge to fall, and take a new snapshot.

The write side reports full and almost-full against the latest read-pointer copy it has received. The read side reports empty and almost-empty against the latest write-pointer copy. Those copies can be stale, so the flags are pessimistic: they never allow an overflow or an underflow. The read port works first-word-fall-through: while the FIFO is not empty, `rd_data` shows the oldest word, and `rd_en` consumes that word.

Handshake sender states are `TX_LOAD`, `TX_AWAIT_ACK` and `TX_AWAIT_RELEASE`, with these transitions:
- `TX_LOAD` to `TX_AWAIT_ACK`: always. This transition captures the snapshot and raises ready.
- `TX_AWAIT_ACK` to `TX_AWAIT_RELEASE`: when the synchronized acknowledge is high. Ready drops here.
- `TX_AWAIT_RELEASE` to `TX_LOAD`: when the synchronized acknowledge is low.

Receiver states are `RX_LISTEN` and `RX_ACKING`, with these transitions:
- `RX_LISTEN` to `RX_ACKING`: when the synchronized ready is high. This transition loads the copy and raises the acknowledge.
- `RX_ACKING` to `RX_LISTEN`: when the synchronized ready is low. The acknowledge drops here.

Top module: `hsafifo`

## Requirements
- R1: After both resets, `rd_empty`=1, `rd_almost_empty`=1, `wr_full`=0 and `wr_almost_full`=0.
- R2: Words come out of `rd_data` in the order they were accepted. `rd_data` shows the oldest stored word whenever `rd_empty` is 0.
- R3: With the default depth of 8, `wr_full` rises once 8 words are stored. A write while `wr_full`=1 is dropped: the 8 words read out afterwards are the original ones, and the FIFO is empty after them.
- R4: A read while `rd_empty`=1 has no effect. A word written afterwards is the next word read out.
- R5: Once the write side has seen a settled read pointer, `wr_almost_full` is 1 exactly when the stored count is at least `AFULL_LVL` (default 6).
- R6: Once the read side has seen a settled write pointer, `rd_almost_empty` is 1 exactly when the stored count is at most `AEMPTY_LVL` (default 2).
- R7: A write to an empty FIFO does not clear `rd_empty` before at least two read-clock edges have passed. The pointer must first travel through the handshake.
- R8: After one side stops moving its pointer, the far side's flags match the true count within 60 cycles of the slower clock. A snapshot stays unchanged from the moment ready is raised until the acknowledge is seen.
- R9: `wr_full` stays high for at least one write-clock edge after a read frees a slot. Neither side ever computes an occupancy above the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room, as seen by the write side |
| wr_almost_full | output | 1 | Count at or above AFULL_LVL |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_en | input | 1 | Consume the word on rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| rd_empty | output | 1 | Nothing stored, as seen by the read side |
| rd_almost_empty | output | 1 | Count at or below AEMPTY_LVL |

## Verification
A snapshot that is corrupted or taken too early shows up as a wrong flag once the handshake has settled, within a few dozen cycles. Because pointers are binary, a torn value lands far from the true count, so the flag error tends to be large rather than off by one. A pointer that moves while its side is blocked shows up at the ports directly. Either a stored word is overwritten, which gives a data mismatch on the next drain, or a stale word is re-read. An acknowledge that is never returned freezes every later transfer. The symptom is a flag that never clears after traffic, which the settled-flag checks catch.

// File: rtl/hsafifo_pkg.sv
package hsafifo_pkg;
    typedef enum logic [1:0] {
        TX_LOAD,
        TX_AWAIT_ACK,
        TX_AWAIT_RELEASE
    } tx_state_e;

    typedef enum logic {
        RX_LISTEN,
        RX_ACKING
    } rx_state_e;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/snap_tx.sv
module snap_tx
    import hsafifo_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] live_ptr,
    input  logic          ack_async,
    output logic [PW-1:0] hold_q,
    output logic          rdy_q
);
    logic      ack_m, ack_s;
    tx_state_e state_q, state_d;

    // two-flop synchronizer for the returning acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_m <= 1'b0;
            ack_s <= 1'b0;
        end else begin
            ack_m <= ack_async;
            ack_s <= ack_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_LOAD:          state_d = TX_AWAIT_ACK;
            TX_AWAIT_ACK:     if (ack_s)  state_d = TX_AWAIT_RELEASE;
            TX_AWAIT_RELEASE: if (!ack_s) state_d = TX_LOAD;
            default:          state_d = TX_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            unique case (state_q)
                TX_LOAD: begin
                    hold_q <= live_ptr;
                    rdy_q  <= 1'b1;
                end
                TX_AWAIT_ACK: if (ack_s) rdy_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> $stable(hold_q));

    // R8
    ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(!ack_s));
endmodule

// File: rtl/snap_rx.sv
module snap_rx
    import hsafifo_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rdy_async,
    input  logic [PW-1:0] hold_in,
    output logic [PW-1:0] copy_q,
    output logic          ack_q
);
    logic      rdy_m, rdy_s;
    rx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_m <= 1'b0;
            rdy_s <= 1'b0;
        end else begin
            rdy_m <= rdy_async;
            rdy_s <= rdy_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_LISTEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_LISTEN: if (rdy_s)  state_d = RX_ACKING;
            RX_ACKING: if (!rdy_s) state_d = RX_LISTEN;
            default:   state_d = RX_LISTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RX_LISTEN: if (rdy_s) begin
                    copy_q <= hold_in;
                    ack_q  <= 1'b1;
                end
                RX_ACKING: if (!rdy_s) ack_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(rdy_s));
endmodule

// File: rtl/ptr_side.sv
module ptr_side #(
    parameter int ADDR_W   = 3,
    parameter bit IS_WRITE = 1'b1,
    parameter int NEAR_LVL = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [ADDR_W:0] far_ptr,
    output logic [ADDR_W:0] ptr_q,
    output logic            block,
    output logic            near,
    output logic            fire
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] NEAR_P  = PW'(NEAR_LVL);

    logic [PW-1:0] occ;

    generate
        if (IS_WRITE) begin : g_wr
            assign occ   = ptr_q - far_ptr;
            assign block = (occ == DEPTH_P);
            assign near  = (occ >= NEAR_P);
        end else begin : g_rd
            assign occ   = far_ptr - ptr_q;
            assign block = (occ == '0);
            assign near  = (occ <= NEAR_P);
        end
    endgenerate

    assign fire = req && !block;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (fire) ptr_q <= ptr_q + 1'b1;
    end

    // R3 R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && block) |=> $stable(ptr_q));

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);
endmodule

// File: rtl/hsafifo.sv
module hsafifo #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int AFULL_LVL  = 6,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wptr, rptr;
    logic [PW-1:0] w_hold, r_hold;
    logic [PW-1:0] wptr_at_rd, rptr_at_wr;
    logic          w_rdy, r_rdy, ack_to_w, ack_to_r;
    logic          w_fire, r_fire;

    ptr_side #(.ADDR_W(ADDR_W), .IS_WRITE(1'b1), .NEAR_LVL(AFULL_LVL)) u_wside (
        .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_en), .far_ptr(rptr_at_wr),
        .ptr_q(wptr), .block(wr_full), .near(wr_almost_full), .fire(w_fire)
    );

    ptr_side #(.ADDR_W(ADDR_W), .IS_WRITE(1'b0), .NEAR_LVL(AEMPTY_LVL)) u_rside (
        .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_en), .far_ptr(wptr_at_rd),
        .ptr_q(rptr), .block(rd_empty), .near(rd_almost_empty), .fire(r_fire)
    );

    // write pointer: write domain -> read domain
    snap_tx #(.PW(PW)) u_wtx (
        .clk(wr_clk), .rst_n(wr_rst_n), .live_ptr(wptr),
        .ack_async(ack_to_w), .hold_q(w_hold), .rdy_q(w_rdy)
    );
    snap_rx #(.PW(PW)) u_rrx (
        .clk(rd_clk), .rst_n(rd_rst_n), .rdy_async(w_rdy),
        .hold_in(w_hold), .copy_q(wptr_at_rd), .ack_q(ack_to_w)
    );

    // read pointer: read domain -> write domain
    snap_tx #(.PW(PW)) u_rtx (
        .clk(rd_clk), .rst_n(rd_rst_n), .live_ptr(rptr),
        .ack_async(ack_to_r), .hold_q(r_hold), .rdy_q(r_rdy)
    );
    snap_rx #(.PW(PW)) u_wrx (
        .clk(wr_clk), .rst_n(wr_rst_n), .rdy_async(r_rdy),
        .hold_in(r_hold), .copy_q(rptr_at_wr), .ack_q(ack_to_r)
    );

    afifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk(wr_clk), .we(w_fire), .waddr(wptr[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rptr[ADDR_W-1:0]), .rdata(rd_data)
    );

    // R4
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty) |=> $stable(rptr));
endmodule

// File: tb/hsafifo_tb.sv
module hsafifo_tb;
    localparam int DEPTH = 8;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wr_full, wr_almost_full, rd_empty, rd_almost_empty;

    int nchk = 0, nfail = 0;
    logic [7:0] exp_q[$];
    logic [7:0] seq = 8'h10;
    logic [11:0] vec;
    logic [7:0] saved;

    // {writes[11:8], reads[7:4], empty, almost_empty, almost_full, full}
    localparam logic [11:0] PLAN [8] = '{
        12'h300, 12'h014, 12'h402, 12'h010,
        12'h303, 12'h08C, 12'h214, 12'h56C
    };

    always #2 wr_clk = ~wr_clk;
    always #3 rd_clk = ~rd_clk;

    hsafifo u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [7:0] d);
        @(negedge wr_clk);
        if (exp_q.size() < DEPTH) exp_q.push_back(d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_word();
        logic [7:0] e;
        @(negedge rd_clk);
        e = exp_q.pop_front();
        chk(rd_data == e, "R2", "read data", rd_data, e);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (60) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();
        // R1 reset state
        chk(rd_empty == 1'b1,        "R1", "empty",        rd_empty, 1);
        chk(rd_almost_empty == 1'b1, "R1", "almost_empty", rd_almost_empty, 1);
        chk(wr_full == 1'b0,         "R1", "full",         wr_full, 0);
        chk(wr_almost_full == 1'b0,  "R1", "almost_full",  wr_almost_full, 0);

        // table walk: R2 data, R5 R6 flags, R8 settled flags
        for (int i = 0; i < 8; i++) begin
            vec = PLAN[i];
            for (int k = 0; k < int'(vec[11:8]); k++) begin
                wr_word(seq);
                seq = seq + 1'b1;
            end
            settle();
            for (int k = 0; k < int'(vec[7:4]); k++) rd_word();
            settle();
            chk(rd_empty == vec[3],        "R8", "empty",        rd_empty, vec[3]);
            chk(rd_almost_empty == vec[2], "R6", "almost_empty", rd_almost_empty, vec[2]);
            chk(wr_almost_full == vec[1],  "R5", "almost_full",  wr_almost_full, vec[1]);
            chk(wr_full == vec[0],         "R8", "full",         wr_full, vec[0]);
        end

        // R7: empty holds after a write into an empty FIFO
        wr_word(seq);
        seq = seq + 1'b1;
        @(posedge rd_clk);
        @(posedge rd_clk);
        #1;
        chk(rd_empty == 1'b1, "R7", "empty right after write", rd_empty, 1);
        settle();
        chk(rd_empty == 1'b0, "R7", "empty after transfer", rd_empty, 0);
        rd_word();
        settle();

        // R3: fill, then writes while full are dropped
        for (int k = 0; k < DEPTH; k++) begin
            wr_word(seq);
            seq = seq + 1'b1;
        end
        settle();
        chk(wr_full == 1'b1, "R3", "full at depth", wr_full, 1);
        for (int k = 0; k < 3; k++) begin
            wr_word(seq);
            seq = seq + 1'b1;
        end
        settle();
        // R9: full pessimistic right after a read
        rd_word();
        @(posedge wr_clk);
        #1;
        chk(wr_full == 1'b1, "R9", "full held after read", wr_full, 1);
        settle();
        chk(wr_full == 1'b0, "R9", "full released", wr_full, 0);
        for (int k = 0; k < DEPTH - 1; k++) rd_word();
        settle();
        chk(rd_empty == 1'b1, "R3", "empty after drain of dropped writes", rd_empty, 1);

        // R4: reads while empty are ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
        end
        saved = seq;
        wr_word(seq);
        seq = seq + 1'b1;
        settle();
        chk(rd_empty == 1'b0, "R4", "one word present", rd_empty, 0);
        chk(rd_data == saved, "R4", "word after empty reads", rd_data, saved);
        rd_word();
        settle();
        chk(rd_empty == 1'b1, "R4", "empty again", rd_empty, 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule